// File: doc/BRIEF.md
# Cascadable Reload Timer Pair with Wake-Up Delay

This block holds two 8-bit down-counters, timer A and timer B, each paired with a reload latch. A count pulse moves a counter one step towards zero. The pulse after the counter has reached zero is an overflow: the counter takes its latch value again and the timer raises a one-cycle interrupt request. A latch value of n therefore gives one overflow every n+1 count pulses.

Timer A counts either the system clock divided by 16 or the rising edges of an external pin. Timer B has four choices: the clock divided by 16, the clock divided by 2, the overflow of timer A, or the external pin. When timer B follows timer A's overflow, the pair forms one longer divider with timer A as an 8-bit prescaler.

The block also times the wake-up delay that lets an oscillator settle. The controller has two states. In WAKE, both timers are forced to fixed values (FF in timer A, 07 in timer B), both are chained, and timer A counts the clock divided by 16. In RUN, the timers follow the select inputs and accept latch writes. Reset puts the block in WAKE. The transition named stop_entry goes from RUN to WAKE when a stop request arrives. The transition named wake_done goes from WAKE to RUN on timer B's overflow and raises a single-cycle release pulse.

Top module: `reload_timer_pair`

## Requirements
- R1: While reset is asserted and right after it, `irq_a`, `irq_b` and `osc_ready` are low. Reset loads FF into both the latch and the counter of timer A, loads 07 into both for timer B, and enters WAKE.
- R2: `osc_ready` pulses high for exactly one cycle. It first appears after the 32768th rising clock edge following reset release (16 × 256 × 8), and that edge moves the block to RUN.
- R3: In RUN, a high `stop_req` at a rising edge performs stop_entry. The prescaler restarts, the preload values of R1 are applied, and `osc_ready` pulses after the 32768th edge following that edge.
- R4: In WAKE, latch writes and the values of `src_a_sel` and `src_b_sel` have no effect, `stop_req` is ignored, and neither interrupt request is raised.
- R5: With latch value n, a timer overflows once every n+1 count pulses. On the overflow pulse it reloads from its latch, and its interrupt output is high for one cycle, one cycle after the overflow.
- R6: A latch write in RUN loads the same value into the counter at once. A count pulse in the same cycle is discarded.
- R7: `src_a_sel` = 0 selects the clock divided by 16, which gives one pulse every 16 cycles. `src_a_sel` = 1 selects rising edges of `ext_clk`.
- R8: `src_b_sel` encodings: 00 selects the clock divided by 16, 01 the clock divided by 2, 10 the overflow of timer A, and 11 rising edges of `ext_clk`.
- R9: `ext_clk` passes through a two-stage synchronizer. Each rising edge counts once, provided the high and low phases each last at least 4 clock cycles.
- R10: After wake_done, each latch still holds its preload value. With no further write, timer B on the divide-by-2 source overflows every 16 cycles.
- R11: A latch value of 0 makes every count pulse an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Stop-mode request, sampled in RUN |
| lat_a_we | input | 1 | Write strobe for timer A's latch |
| lat_b_we | input | 1 | Write strobe for timer B's latch |
| lat_wdata | input | 8 | Latch write value |
| src_a_sel | input | 1 | Timer A count source select |
| src_b_sel | input | 2 | Timer B count source select |
| ext_clk | input | 1 | External count pin |
| irq_a | output | 1 | Timer A overflow request pulse |
| irq_b | output | 1 | Timer B overflow request pulse |
| osc_ready | output | 1 | Single-cycle wake-up release pulse |

## Verification
A wrong counter, latch or prescaler value appears on the ports as an overflow interval that is off by one or more count pulses. The bench measures consecutive intervals, so such an error shows within one or two periods of the source in use. A wrong preload or a missed force in WAKE moves the release pulse away from cycle 32768, or lets an interrupt through during the wake window. Both show up within one wake sequence. A write that loads only the latch and not the counter is caught in the following overflow, by counting external pulses around a write made mid-count.

// File: rtl/rtp_pkg.sv
package rtp_pkg;
    typedef enum logic {
        ST_WAKE = 1'b0,
        ST_RUN  = 1'b1
    } rtp_state_e;

    localparam logic       SRC_A_DIV16 = 1'b0;
    localparam logic       SRC_A_EXT   = 1'b1;
    localparam logic [1:0] SRC_B_DIV16 = 2'b00;
    localparam logic [1:0] SRC_B_DIV2  = 2'b01;
    localparam logic [1:0] SRC_B_CHAIN = 2'b10;
    localparam logic [1:0] SRC_B_EXT   = 2'b11;
endpackage

// File: rtl/rtp_prescaler.sv
module rtp_prescaler #(
    parameter int DIV_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_slow_o,
    output logic tick_fast_o
);
    logic [DIV_LOG2-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_q <= '0;
        else if (clr_i) div_q <= '0;
        else            div_q <= div_q + 1'b1;
    end

    assign tick_slow_o = &div_q;
    assign tick_fast_o = div_q[0];

    // R3: a restart leaves a full divide period before the next slow tick
    assert_clear_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !tick_slow_o);
    // R7: the slow tick never lasts two cycles
    assert_slow_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow_o |=> !tick_slow_o);
endmodule

// File: rtl/rtp_edge_sync.sv
module rtp_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-1:0], pin_i};
    end

    assign rise_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    // R9: one rising edge gives exactly one pulse
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/rtp_down_timer.sv
module rtp_down_timer #(
    parameter int           W       = 8,
    parameter logic [W-1:0] PRELOAD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         force_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         pulse_i,
    output logic         ovf_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lat_q;
    logic         at_zero;

    assign at_zero = (cnt_q == '0);
    assign ovf_o   = pulse_i & at_zero & ~force_i & ~wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= PRELOAD;
            cnt_q <= PRELOAD;
        end else if (force_i) begin
            lat_q <= PRELOAD;
            cnt_q <= PRELOAD;
        end else if (wr_i) begin
            lat_q <= wr_data_i;
            cnt_q <= wr_data_i;
        end else if (pulse_i) begin
            cnt_q <= at_zero ? lat_q : cnt_q - 1'b1;
        end
    end

    // R5: a pulse on a nonzero count steps it down by one
    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && !force_i && !wr_i && cnt_q != '0) |=> cnt_q == W'($past(cnt_q) - 1'b1));
    // R5: the overflow pulse reloads the latch value
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> cnt_q == $past(lat_q));
    // R6: a write loads the counter immediately
    assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !force_i) |=> cnt_q == $past(wr_data_i));
    // R1: the forced preload lands in the counter and the latch
    assert_preload_R1: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> (cnt_q == PRELOAD && lat_q == PRELOAD));
    // R4: without a write or a preload the latch holds
    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_i && !wr_i) |=> $stable(lat_q));
endmodule

// File: rtl/reload_timer_pair.sv
module reload_timer_pair #(
    parameter int           W        = 8,
    parameter int           DIV_LOG2 = 4,
    parameter logic [W-1:0] PRE_A    = 8'hFF,
    parameter logic [W-1:0] PRE_B    = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_req,
    input  logic         lat_a_we,
    input  logic         lat_b_we,
    input  logic [W-1:0] lat_wdata,
    input  logic         src_a_sel,
    input  logic [1:0]   src_b_sel,
    input  logic         ext_clk,
    output logic         irq_a,
    output logic         irq_b,
    output logic         osc_ready
);
    import rtp_pkg::*;

    rtp_state_e state_q, state_d;
    logic running, stop_entry, wake_done;
    logic tick_slow, tick_fast, ext_rise;
    logic pulse_a, pulse_b, ovf_a, ovf_b;

    assign running    = (state_q == ST_RUN);
    assign stop_entry = running && stop_req;
    assign wake_done  = !running && ovf_b;

    rtp_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr_i(stop_entry),
        .tick_slow_o(tick_slow), .tick_fast_o(tick_fast)
    );

    rtp_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ext_clk), .rise_o(ext_rise)
    );

    // count-source selection; WAKE forces the chained wake-up sources
    always_comb begin
        pulse_a = tick_slow;
        pulse_b = ovf_a;
        if (running) begin
            pulse_a = (src_a_sel == SRC_A_EXT) ? ext_rise : tick_slow;
            unique case (src_b_sel)
                SRC_B_DIV16: pulse_b = tick_slow;
                SRC_B_DIV2:  pulse_b = tick_fast;
                SRC_B_CHAIN: pulse_b = ovf_a;
                SRC_B_EXT:   pulse_b = ext_rise;
            endcase
        end
    end

    rtp_down_timer #(.W(W), .PRELOAD(PRE_A)) u_tmr_a (
        .clk(clk), .rst_n(rst_n), .force_i(stop_entry),
        .wr_i(lat_a_we && running), .wr_data_i(lat_wdata),
        .pulse_i(pulse_a), .ovf_o(ovf_a)
    );

    rtp_down_timer #(.W(W), .PRELOAD(PRE_B)) u_tmr_b (
        .clk(clk), .rst_n(rst_n), .force_i(stop_entry),
        .wr_i(lat_b_we && running), .wr_data_i(lat_wdata),
        .pulse_i(pulse_b), .ovf_o(ovf_b)
    );

    // next-state logic: stop_entry and wake_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAKE: if (ovf_b)    state_d = ST_RUN;
            ST_RUN:  if (stop_req) state_d = ST_WAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAKE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_ready <= 1'b0;
            irq_a     <= 1'b0;
            irq_b     <= 1'b0;
        end else begin
            osc_ready <= wake_done;
            irq_a     <= running && ovf_a;
            irq_b     <= running && ovf_b;
        end
    end

    // R3: a stop request in RUN enters WAKE
    assert_stop_enters_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_entry |=> state_q == ST_WAKE);
    // R2: the release pulse is one cycle wide
    assert_release_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_ready |=> !osc_ready);
    // R2: release appears only on the WAKE-to-RUN step
    assert_release_on_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        osc_ready |-> (state_q == ST_RUN && $past(state_q) == ST_WAKE));
    // R4: no interrupt request stems from the wake sequence
    assert_no_irq_in_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_a || irq_b) |-> $past(state_q) == ST_RUN);
endmodule

// File: tb/reload_timer_pair_bench.sv
module reload_timer_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       lat_a_we = 1'b0, lat_b_we = 1'b0;
    logic [7:0] lat_wdata = 8'h00;
    logic       src_a_sel = 1'b0;
    logic [1:0] src_b_sel = 2'b00;
    logic       ext_clk = 1'b0;
    logic       irq_a, irq_b, osc_ready;

    int checks = 0, fails = 0;
    int irqa_seen = 0, irqb_seen = 0;
    bit done = 1'b0;

    localparam int WAKE_CYC = 16 * 256 * 8;

    always #10 clk = ~clk;

    reload_timer_pair u_reload_timer_pair (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .lat_a_we(lat_a_we), .lat_b_we(lat_b_we), .lat_wdata(lat_wdata),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .ext_clk(ext_clk),
        .irq_a(irq_a), .irq_b(irq_b), .osc_ready(osc_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_lat(input bit sel_b, input logic [7:0] v);
        @(negedge clk);
        lat_wdata = v;
        if (sel_b) lat_b_we = 1'b1; else lat_a_we = 1'b1;
        @(negedge clk);
        lat_a_we = 1'b0;
        lat_b_we = 1'b0;
    endtask

    // cycles until the next request pulse on the chosen timer
    task automatic wait_irq(input bit sel_b, output int n);
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            n++;
            if (sel_b ? irq_b : irq_a) break;
        end
    endtask

    task automatic measure(input bit sel_b, input int exp, input string tag);
        int n;
        wait_irq(sel_b, n);
        wait_irq(sel_b, n);
        check(n == exp, tag, n, exp);
        wait_irq(sel_b, n);
        check(n == exp, {tag, " repeat"}, n, exp);
    endtask

    task automatic ext_pulse();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            ext_clk = 1'b1;
            irqa_seen += int'(irq_a);
            irqb_seen += int'(irq_b);
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ext_clk = 1'b0;
            irqa_seen += int'(irq_a);
            irqb_seen += int'(irq_b);
        end
    endtask

    // counts edges from the starting edge to the release pulse
    task automatic wake_window(input string tag, input bit poke);
        int first = 0, highs = 0, irqs = 0;
        for (int n = 1; n < WAKE_CYC + 200; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (osc_ready) begin
                highs++;
                if (first == 0) first = n;
            end
            if (irq_a || irq_b) irqs++;
            if (poke && n == 100) begin
                lat_wdata = 8'h00; lat_a_we = 1'b1; lat_b_we = 1'b1;
                src_b_sel = 2'b01; src_a_sel = 1'b1; stop_req = 1'b1;
            end
            if (poke && n == 101) begin
                lat_a_we = 1'b0; lat_b_we = 1'b0; stop_req = 1'b0;
            end
            if (first != 0 && n > first + 3) break;
        end
        check(first == WAKE_CYC, {tag, " release cycle"}, first, WAKE_CYC);
        check(highs == 1, "R2 release width", highs, 1);
        check(irqs == 0, "R4 no irq during wake", irqs, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!irq_a && !irq_b && !osc_ready, "R1 outputs in reset",
              int'({irq_a, irq_b, osc_ready}), 0);
        rst_n = 1'b1;
        wake_window("R2 reset", 1'b0);
    endtask

    task automatic t_div16();
        src_a_sel = 1'b0;
        write_lat(1'b0, 8'd2);
        measure(1'b0, 48, "R5 R7 clk/16 latch 2");
    endtask

    task automatic t_timer_b_sources();
        src_b_sel = 2'b01;
        write_lat(1'b1, 8'd4);
        measure(1'b1, 10, "R8 clk/2 latch 4");
        write_lat(1'b1, 8'd0);
        measure(1'b1, 2, "R11 clk/2 latch 0");
        src_b_sel = 2'b00;
        measure(1'b1, 16, "R8 R11 clk/16 latch 0");
    endtask

    task automatic t_chain();
        src_a_sel = 1'b0;
        src_b_sel = 2'b10;
        write_lat(1'b0, 8'd1);
        write_lat(1'b1, 8'd2);
        measure(1'b1, 96, "R8 chained B");
        measure(1'b0, 32, "R5 prescaler A");
    endtask

    task automatic t_ext();
        src_a_sel = 1'b1;
        src_b_sel = 2'b11;
        write_lat(1'b0, 8'd3);
        write_lat(1'b1, 8'd1);
        irqa_seen = 0; irqb_seen = 0;
        repeat (3) ext_pulse();
        check(irqa_seen == 0, "R9 ext A after 3 edges", irqa_seen, 0);
        check(irqb_seen == 1, "R9 R8 ext B after 3 edges", irqb_seen, 1);
        ext_pulse();
        check(irqa_seen == 1, "R7 ext A after 4 edges", irqa_seen, 1);
        check(irqb_seen == 2, "R8 ext B after 4 edges", irqb_seen, 2);
    endtask

    task automatic t_write_midcount();
        src_a_sel = 1'b1;
        write_lat(1'b0, 8'd5);
        irqa_seen = 0;
        repeat (2) ext_pulse();
        write_lat(1'b0, 8'd2);
        repeat (2) ext_pulse();
        check(irqa_seen == 0, "R6 no overflow before reloaded count", irqa_seen, 0);
        ext_pulse();
        check(irqa_seen == 1, "R6 overflow after write value", irqa_seen, 1);
    endtask

    task automatic t_stop();
        @(negedge clk);
        stop_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        stop_req = 1'b0;
        irq_dummy();
        wake_window("R3 stop", 1'b1);
        src_a_sel = 1'b0;
        src_b_sel = 2'b01;
        measure(1'b1, 16, "R10 preload kept in B latch");
    endtask

    task automatic irq_dummy();
        check(!osc_ready, "R3 no release at stop entry", int'(osc_ready), 0);
    endtask

    initial begin
        t_reset();
        t_div16();
        t_timer_b_sources();
        t_chain();
        t_ext();
        t_write_midcount();
        t_stop();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule